// File: doc/BRIEF.md
# Prefix-Gated Condition Flag Register

This block holds the five condition flags of a processor: sticky, negative, zero, overflow and carry. When an instruction retires, the block writes that instruction's flag results into the register. The exception is a one-shot inhibit prefix that arrived just before the instruction. While the prefix is pending, results that come from the ALU are dropped and the flags keep their old values.

The decoder, ALU, interrupt sequencer and stack logic are outside the block. They deliver a class code for the retiring instruction, the ALU's flag vector and an explicit load value.

Some instruction classes write the flags directly. These are the immediate AND and OR on the flags, the status pop, interrupt entry and return, and context switch. They write the flags whether or not a prefix is pending. Of these, the AND, OR and status pop, together with the interrupt-level write, leave the pending prefix armed for the instruction that follows. A string instruction retired under a pending prefix is an illegal combination, and the block reports it with an error pulse.

Top module: `cflag_gate`

## Requirements
- R1: After reset, `flags` is 0, `prefix_pending` is 0 and `misuse_err` is 0.
- R2: A `prefix_seen` pulse sets `prefix_pending` on the next cycle. Several pulses do not accumulate: a single consuming instruction clears the latch after any number of them.
- R3: Class 0 (ALU instruction) retired with no pending prefix loads `flags` from `alu_flags`, with bit order {T,N,Z,V,C} from bit 4 down to bit 0. With a prefix pending, `flags` is unchanged. Either way the prefix is consumed.
- R4: Class 1 (instruction that writes no flags) leaves `flags` unchanged and consumes a pending prefix.
- R5: Class 2 sets `flags` to `flags & load_val` and class 3 sets it to `flags | load_val`. Both apply regardless of the prefix, and both leave `prefix_pending` unchanged.
- R6: Class 4 (status pop) loads `flags` from `load_val` regardless of the prefix and leaves `prefix_pending` unchanged.
- R7: Class 5 (software interrupt, interrupt return, context switch) loads `flags` from `load_val` regardless of the prefix and consumes it.
- R8: Class 6 (interrupt-level write) leaves `flags` unchanged and keeps the prefix, so the next ALU instruction is still inhibited.
- R9: Class 7 (string instruction) behaves like class 0 for flags and for the prefix. Retired with a prefix pending, it raises `misuse_err` for exactly the following cycle.
- R10: `irq_entry` clears `prefix_pending` on the next cycle, overriding a same-cycle `prefix_seen`, and leaves `flags` unchanged.
- R11: When `retire` is low, `flags` holds whatever `iclass`, `alu_flags` and `load_val` are.
- R12: When `prefix_seen` and `retire` occur in the same cycle, the retiring instruction sees the old pending state, and `prefix_pending` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | Instruction-complete strobe |
| iclass | input | 3 | Class code of the retiring instruction |
| prefix_seen | input | 1 | Inhibit prefix decoded |
| irq_entry | input | 1 | Hardware interrupt entry |
| alu_flags | input | 5 | ALU flag results {T,N,Z,V,C} |
| load_val | input | 5 | Explicit flag value or mask |
| flags | output | 5 | Current flags {T,N,Z,V,C} |
| prefix_pending | output | 1 | Inhibit prefix armed |
| misuse_err | output | 1 | One-cycle pulse: string instruction under prefix |

## Verification
The hardest situation to reach is an inhibit that survives through several retirements. A prefix must be armed, then carried across one or more retained classes (interrupt-level write, AND/OR, status pop), and only then meet an ALU instruction. The bench builds these chains on purpose. It also sweeps every class against both prefix states, starting each case from a known flag value loaded through the status-pop class. A reference model written as a plain per-class case statement supplies the expected values.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  localparam int FLAG_W = 5;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    IC_ALU      = 3'd0,
    IC_QUIET    = 3'd1,
    IC_AND_IMM  = 3'd2,
    IC_OR_IMM   = 3'd3,
    IC_STAT_POP = 3'd4,
    IC_FORCE_LD = 3'd5,
    IC_LVL_WR   = 3'd6,
    IC_STRING   = 3'd7
  } iclass_e;

  typedef enum logic [1:0] {
    LD_REPLACE = 2'd0,
    LD_AND     = 2'd1,
    LD_OR      = 2'd2
  } load_op_e;

  function automatic logic [FLAG_W-1:0] apply_load(
    input load_op_e op,
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] val);
    case (op)
      LD_AND:  apply_load = cur & val;
      LD_OR:   apply_load = cur | val;
      default: apply_load = val;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] pick_next(
    input logic explicit_wr,
    input logic alu_wr,
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] from_load,
    input logic [FLAG_W-1:0] from_alu);
    if (explicit_wr)  pick_next = from_load;
    else if (alu_wr)  pick_next = from_alu;
    else              pick_next = cur;
  endfunction
endpackage

// File: rtl/cflag_class_dec.sv
module cflag_class_dec
  import cflag_pkg::*;
#(
  parameter int CLS_W = cflag_pkg::CLS_W
) (
  input  logic [CLS_W-1:0] cls,
  output logic             uses_alu,
  output logic             explicit_wr,
  output logic             keeps_prefix,
  output logic             is_string,
  output load_op_e         load_op
);
  always_comb begin
    uses_alu     = 1'b0;
    explicit_wr  = 1'b0;
    keeps_prefix = 1'b0;
    is_string    = 1'b0;
    load_op      = LD_REPLACE;
    case (cls)
      IC_ALU:      uses_alu = 1'b1;
      IC_QUIET:    ;
      IC_AND_IMM: begin explicit_wr = 1'b1; keeps_prefix = 1'b1; load_op = LD_AND; end
      IC_OR_IMM:  begin explicit_wr = 1'b1; keeps_prefix = 1'b1; load_op = LD_OR;  end
      IC_STAT_POP: begin explicit_wr = 1'b1; keeps_prefix = 1'b1; end
      IC_FORCE_LD: explicit_wr = 1'b1;
      IC_LVL_WR:   keeps_prefix = 1'b1;
      IC_STRING:  begin uses_alu = 1'b1; is_string = 1'b1; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/cflag_prefix_latch.sv
module cflag_prefix_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic consume,
  input  logic flush,
  input  logic misuse_now,
  output logic pending,
  output logic misuse_q
);
  logic pend_nxt;

  always_comb begin
    if (flush)        pend_nxt = 1'b0;
    else if (set_req) pend_nxt = 1'b1;
    else if (consume) pend_nxt = 1'b0;
    else              pend_nxt = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      misuse_q <= 1'b0;
    end else begin
      pending  <= pend_nxt;
      misuse_q <= misuse_now;
    end
  end
endmodule

// File: rtl/cflag_store.sv
module cflag_store #(
  parameter int FLAG_W = cflag_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[b] <= 1'b0;
      else if (wr_en) q[b] <= nxt[b];
    end
  end
endmodule

// File: rtl/cflag_gate.sv
module cflag_gate
  import cflag_pkg::*;
#(
  parameter int FLAG_W = cflag_pkg::FLAG_W,
  parameter int CLS_W  = cflag_pkg::CLS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic [CLS_W-1:0]  iclass,
  input  logic              prefix_seen,
  input  logic              irq_entry,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic [FLAG_W-1:0] load_val,
  output logic [FLAG_W-1:0] flags,
  output logic              prefix_pending,
  output logic              misuse_err
);
  logic     dec_alu, dec_explicit, dec_keep, dec_string;
  load_op_e dec_op;

  logic              ev_alu_write;
  logic              ev_alu_blocked;
  logic              ev_explicit_write;
  logic              ev_prefix_consume;
  logic              ev_misuse;
  logic [FLAG_W-1:0] load_result;
  logic [FLAG_W-1:0] flags_nxt;

  cflag_class_dec #(.CLS_W(CLS_W)) u_dec (
    .cls          (iclass),
    .uses_alu     (dec_alu),
    .explicit_wr  (dec_explicit),
    .keeps_prefix (dec_keep),
    .is_string    (dec_string),
    .load_op      (dec_op)
  );

  // Named events: the pending state used is the value before this edge.
  assign ev_explicit_write = retire & dec_explicit;
  assign ev_alu_write      = retire & dec_alu & ~prefix_pending;
  assign ev_alu_blocked    = retire & dec_alu &  prefix_pending;
  assign ev_prefix_consume = retire & ~dec_keep;
  assign ev_misuse         = retire & dec_string & prefix_pending;

  assign load_result = apply_load(dec_op, flags, load_val);
  assign flags_nxt   = pick_next(ev_explicit_write, ev_alu_write,
                                 flags, load_result, alu_flags);

  cflag_store #(.FLAG_W(FLAG_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ev_explicit_write | ev_alu_write),
    .nxt   (flags_nxt),
    .q     (flags)
  );

  cflag_prefix_latch u_pfx (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req    (prefix_seen),
    .consume    (ev_prefix_consume),
    .flush      (irq_entry),
    .misuse_now (ev_misuse),
    .pending    (prefix_pending),
    .misuse_q   (misuse_err)
  );
endmodule

// File: rtl/cflag_gate_chk.sv
module cflag_gate_chk #(
  parameter int FLAG_W = 5,
  parameter int CLS_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire,
  input logic [CLS_W-1:0]  iclass,
  input logic              prefix_seen,
  input logic              irq_entry,
  input logic [FLAG_W-1:0] load_val,
  input logic [FLAG_W-1:0] flags,
  input logic              prefix_pending,
  input logic              misuse_err,
  input logic              ev_alu_blocked
);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(flags));

  assert_prefix_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prefix_seen && !irq_entry) |=> prefix_pending);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> !prefix_pending);

  assert_alu_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alu_blocked |=> $stable(flags));

  assert_pop_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && iclass == 3'd4) |=> flags == $past(load_val));

  assert_force_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && iclass == 3'd5 && !prefix_seen) |=>
      (flags == $past(load_val) && !prefix_pending));

  assert_keep_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && prefix_pending && !irq_entry &&
     (iclass == 3'd2 || iclass == 3'd3 || iclass == 3'd6)) |=> prefix_pending);

  assert_misuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && iclass == 3'd7 && prefix_pending) |=> misuse_err);

  assert_misuse_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && iclass == 3'd7 && prefix_pending) |=> !misuse_err);
endmodule

bind cflag_gate cflag_gate_chk #(.FLAG_W(FLAG_W), .CLS_W(CLS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .retire         (retire),
  .iclass         (iclass),
  .prefix_seen    (prefix_seen),
  .irq_entry      (irq_entry),
  .load_val       (load_val),
  .flags          (flags),
  .prefix_pending (prefix_pending),
  .misuse_err     (misuse_err),
  .ev_alu_blocked (ev_alu_blocked)
);

// File: tb/cflag_gate_test.sv
module cflag_gate_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retire = 1'b0;
  logic [2:0] iclass = 3'd0;
  logic       prefix_seen = 1'b0;
  logic       irq_entry = 1'b0;
  logic [4:0] alu_flags = 5'd0;
  logic [4:0] load_val = 5'd0;
  logic [4:0] flags;
  logic       prefix_pending;
  logic       misuse_err;

  int total = 0;
  int fails = 0;
  logic [4:0] m_f = 5'd0;
  logic       m_p = 1'b0;
  logic       m_e = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cflag_gate uut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .iclass(iclass),
    .prefix_seen(prefix_seen), .irq_entry(irq_entry),
    .alu_flags(alu_flags), .load_val(load_val),
    .flags(flags), .prefix_pending(prefix_pending), .misuse_err(misuse_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Drive at a falling edge, update the model, check at the next falling edge.
  task automatic step(input logic rt, input logic [2:0] c, input logic pf,
                      input logic irq, input logic [4:0] alu, input logic [4:0] ld,
                      input string req, input bit do_chk);
    logic old_p;
    retire = rt; iclass = c; prefix_seen = pf; irq_entry = irq;
    alu_flags = alu; load_val = ld;
    old_p = m_p;
    if (rt) begin
      case (c)
        3'd0, 3'd7: if (!old_p) m_f = alu;
        3'd2: m_f = m_f & ld;
        3'd3: m_f = m_f | ld;
        3'd4, 3'd5: m_f = ld;
        default: ;
      endcase
    end
    m_e = rt && (c == 3'd7) && old_p;
    if (irq) m_p = 1'b0;
    else if (pf) m_p = 1'b1;
    else if (rt && (c == 3'd0 || c == 3'd1 || c == 3'd5 || c == 3'd7)) m_p = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (do_chk) begin
      chk(req, "flags", flags, m_f);
      chk(req, "pending", {4'd0, prefix_pending}, {4'd0, m_p});
      chk(req, "misuse", {4'd0, misuse_err}, {4'd0, m_e});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "flags", flags, 5'd0);
    chk("R1", "pending", {4'd0, prefix_pending}, 5'd0);
    chk("R1", "misuse", {4'd0, misuse_err}, 5'd0);

    // Sweep every class against both prefix states and four flag patterns.
    for (int pend = 0; pend < 2; pend++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 4; k++) begin
          logic [4:0] start, alu, ld;
          start = 5'((k * 7 + 3) % 32);
          alu   = 5'(((31 - start) ^ k) % 32);
          ld    = 5'((k * 11 + 5) % 32);
          step(1'b1, 3'd4, 1'b0, 1'b0, 5'd0, start, "R6", 1'b1);
          if (pend != 0) step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R2", 1'b1);
          step(1'b1, 3'(c), 1'b0, 1'b0, alu, ld, req_of(3'(c)), 1'b1);
          step(1'b1, 3'd1, 1'b0, 1'b0, 5'd0, 5'd0, "R4", 1'b1);
        end
      end
    end

    // R2: three prefixes, one ALU instruction clears the latch.
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R2", 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R2", 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R2", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h15, 5'd0, "R2", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h0a, 5'd0, "R2", 1'b1);

    // R8: level write carries the inhibit across a chain of retained classes.
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R8", 1'b1);
    step(1'b1, 3'd6, 1'b0, 1'b0, 5'h1f, 5'd0, "R8", 1'b1);
    step(1'b1, 3'd3, 1'b0, 1'b0, 5'd0, 5'h04, "R5", 1'b1);
    step(1'b1, 3'd4, 1'b0, 1'b0, 5'd0, 5'h11, "R6", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h0e, 5'd0, "R8", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h0e, 5'd0, "R3", 1'b1);

    // R9: string under prefix, then immediately a string without.
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R9", 1'b1);
    step(1'b1, 3'd7, 1'b0, 1'b0, 5'h13, 5'd0, "R9", 1'b1);
    step(1'b1, 3'd7, 1'b0, 1'b0, 5'h13, 5'd0, "R9", 1'b1);

    // R10: interrupt entry flushes, also against a same-cycle prefix.
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R10", 1'b1);
    step(1'b0, 3'd0, 1'b0, 1'b1, 5'd0, 5'd0, "R10", 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b1, 5'd0, 5'd0, "R10", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h07, 5'd0, "R10", 1'b1);

    // R11: no retire, every class, flags hold.
    for (int c = 0; c < 8; c++)
      step(1'b0, 3'(c), 1'b0, 1'b0, 5'h1b, 5'h00, "R11", 1'b1);

    // R12: prefix with a retiring ALU instruction in the same cycle.
    step(1'b1, 3'd0, 1'b1, 1'b0, 5'h19, 5'd0, "R12", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h02, 5'd0, "R12", 1'b1);

    // R7: forced load under prefix consumes it.
    step(1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 5'd0, "R7", 1'b1);
    step(1'b1, 3'd5, 1'b0, 1'b0, 5'd0, 5'h0c, "R7", 1'b1);
    step(1'b1, 3'd0, 1'b0, 1'b0, 5'h10, 5'd0, "R7", 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule